// File: doc/BRIEF.md
# Gear Ratio Clock Divider Pair

This block turns two unrelated clocks, a controller clock and a fast bus clock, into a pair of slower clocks that run at the same frequency. It first derives a channel clock from the bus clock with a fixed divide-by-four. It then divides the controller clock by M and the channel clock by N. The products satisfy controller/M = channel/N, so an external phase detector can compare the rising edges of the two divided outputs. A two-bit ratio code picks one of four controller-to-channel frequency ratios: 2.0, 1.5, 1.33 or 1.0. Each ratio fixes one M/N pair.

Each domain has its own reset. The reset is asserted at once and released through a synchronizer in that domain. Each domain also gives transfer logic a one-cycle marker at the start of every divided period, so that the logic can find the edges the two domains share. The ratio code is held still whenever either domain is running. It is changed only while both domains are in reset.

Top module: `gear_div_pair`

## Requirements
- R1: The ratio code maps to divisors as follows: 2'b00 gives M=2,N=1; 2'b01 gives M=3,N=2; 2'b10 gives M=4,N=3; 2'b11 gives M=1,N=1.
- R2: The controller divided output repeats every M controller cycles. It is high for floor(M/2) cycles, starting in the first cycle of each period. When M=1 it stays high.
- R3: The channel clock is the bus clock divided by four, at 50% duty. It is high in the first two bus cycles of each channel period.
- R4: The channel divided output repeats every N channel cycles. It is high for floor(N/2) channel cycles, or stays high when N=1. It changes only at a rising edge of the channel clock.
- R5: Each domain raises its marker for exactly one cycle of that domain's clock at the start of every divided period. For the channel domain, one cycle is one channel cycle, which is four bus cycles. When the divisor is 1, the marker is high in every cycle.
- R6: While a domain's reset input is low, that domain's outputs are all 0. After release, the outputs first update at the third rising edge of the domain clock, and that edge opens a new divided period.
- R7: The ratio code applied at reset release governs the whole run. Each release restarts the divide count at zero, whatever the count was when reset arrived.
- R8: Every rising edge of a divided output falls in a cycle where that domain's marker is high. A marker that is high with a divisor above 1 is low in the next period slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctrlClk | input | 1 | Controller clock |
| ctrlRstN | input | 1 | Controller-domain reset, active low, asynchronous assert |
| busClk | input | 1 | Bus clock, four times the channel clock |
| busRstN | input | 1 | Bus/channel-domain reset, active low, asynchronous assert |
| ratioSel | input | 2 | Ratio code, changed only while both resets are low |
| chanClk | output | 1 | Channel clock, bus clock divided by four |
| ctrlDivClk | output | 1 | Controller clock divided by M |
| ctrlMark | output | 1 | Start-of-period marker, controller domain |
| chanDivClk | output | 1 | Channel clock divided by N, in the bus domain |
| chanMark | output | 1 | Start-of-period marker, channel domain |

## Verification
The bench builds the block with its default parameters: a two-stage reset synchronizer, a channel prescale of four and three-bit divide counters. With these values every divisor in the ratio table, including the divide-by-one pass-through, can be reached in a few dozen cycles. The bench sweeps all four ratio codes and computes the expected waveform of each output arithmetically from the cycle index since release. Each code is applied by asserting reset in the middle of a period, so every sweep step also exercises the restart from zero and the exact release latency.

// File: rtl/gear_div_pkg.sv
package gear_div_pkg;

  localparam int DIV_W = 3;

  typedef logic [DIV_W-1:0] divVal_t;

  // Strobes passed from a divide controller to its output datapath.
  typedef struct packed {
    logic advance;      // domain tick: datapath may update
    logic periodStart;  // count is at the first slot of a divided period
    logic highPhase;    // divided output should be high in this slot
  } divStrobe_t;

  typedef struct packed {
    divVal_t ctrlDiv;
    divVal_t chanDiv;
  } divPair_t;

  // Ratio code to divisor pair; the pair keeps ctrl/M equal to chan/N.
  function automatic divPair_t decodeRatio(input logic [1:0] code);
    divPair_t p;
    unique case (code)
      2'b00:   begin p.ctrlDiv = divVal_t'(2); p.chanDiv = divVal_t'(1); end
      2'b01:   begin p.ctrlDiv = divVal_t'(3); p.chanDiv = divVal_t'(2); end
      2'b10:   begin p.ctrlDiv = divVal_t'(4); p.chanDiv = divVal_t'(3); end
      default: begin p.ctrlDiv = divVal_t'(1); p.chanDiv = divVal_t'(1); end
    endcase
    return p;
  endfunction

endpackage

// File: rtl/gear_rst_sync.sv
module gear_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstNIn,
  output logic rstOut
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstNIn) begin
        if (!rstNIn) chain <= '0;
        else         chain <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstNIn) begin
        if (!rstNIn) chain <= '0;
        else         chain <= {chain[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rstOut = ~chain[STAGES-1];
endmodule

// File: rtl/gear_prescale.sv
module gear_prescale #(
  parameter int RATIO = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick,
  output logic phaseClk
);
  localparam int PW = (RATIO > 2) ? $clog2(RATIO) : 1;
  localparam logic [PW-1:0] LAST = PW'(RATIO - 1);
  localparam logic [PW-1:0] HALF = PW'(RATIO / 2);

  logic [PW-1:0] phase;
  logic [PW-1:0] phaseNext;

  // Reset to the last slot so the first edge after release opens a period.
  assign tick      = (phase == LAST);
  assign phaseNext = tick ? '0 : phase + PW'(1);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      phase    <= LAST;
      phaseClk <= 1'b0;
    end else begin
      phase    <= phaseNext;
      phaseClk <= (phaseNext < HALF);
    end
  end
endmodule

// File: rtl/gear_div_ctrl.sv
module gear_div_ctrl
  import gear_div_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  divVal_t    divisor,
  output divStrobe_t strb
);
  divVal_t count;
  divVal_t lastSlot;
  divVal_t halfCount;

  assign lastSlot  = divisor - divVal_t'(1);
  assign halfCount = divisor >> 1;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)       count <= '0;
    else if (tick) count <= (count >= lastSlot) ? '0 : count + divVal_t'(1);
  end

  always_comb begin
    strb.advance     = tick;
    strb.periodStart = (count == '0);
    strb.highPhase   = (divisor == divVal_t'(1)) || (count < halfCount);
  end
endmodule

// File: rtl/gear_div_dp.sv
module gear_div_dp
  import gear_div_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  divStrobe_t strb,
  output logic       divClk,
  output logic       mark
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      divClk <= 1'b0;
      mark   <= 1'b0;
    end else if (strb.advance) begin
      divClk <= strb.highPhase;
      mark   <= strb.periodStart;
    end
  end
endmodule

// File: rtl/gear_div_pair.sv
module gear_div_pair
  import gear_div_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BUS_PRESCALE = 4
) (
  input  logic       ctrlClk,
  input  logic       ctrlRstN,
  input  logic       busClk,
  input  logic       busRstN,
  input  logic [1:0] ratioSel,
  output logic       chanClk,
  output logic       ctrlDivClk,
  output logic       ctrlMark,
  output logic       chanDivClk,
  output logic       chanMark
);
  divPair_t   divs;
  logic       ctrlRst;
  logic       busRst;
  logic       chanTick;
  divStrobe_t ctrlStrb;
  divStrobe_t chanStrb;

  assign divs = decodeRatio(ratioSel);

  gear_rst_sync #(.STAGES(SYNC_STAGES)) u_ctrlRst (
    .clk(ctrlClk), .rstNIn(ctrlRstN), .rstOut(ctrlRst)
  );
  gear_rst_sync #(.STAGES(SYNC_STAGES)) u_busRst (
    .clk(busClk), .rstNIn(busRstN), .rstOut(busRst)
  );

  // Controller domain: advances every cycle.
  gear_div_ctrl u_ctrlCtl (
    .clk(ctrlClk), .rst(ctrlRst), .tick(1'b1),
    .divisor(divs.ctrlDiv), .strb(ctrlStrb)
  );
  gear_div_dp u_ctrlDp (
    .clk(ctrlClk), .rst(ctrlRst), .strb(ctrlStrb),
    .divClk(ctrlDivClk), .mark(ctrlMark)
  );

  // Channel domain: clocked by the bus clock, advancing once per channel cycle.
  gear_prescale #(.RATIO(BUS_PRESCALE)) u_pre (
    .clk(busClk), .rst(busRst), .tick(chanTick), .phaseClk(chanClk)
  );
  gear_div_ctrl u_chanCtl (
    .clk(busClk), .rst(busRst), .tick(chanTick),
    .divisor(divs.chanDiv), .strb(chanStrb)
  );
  gear_div_dp u_chanDp (
    .clk(busClk), .rst(busRst), .strb(chanStrb),
    .divClk(chanDivClk), .mark(chanMark)
  );
endmodule

// File: rtl/gear_div_pair_chk.sv
module gear_div_pair_chk (
  input logic       ctrlClk,
  input logic       ctrlRstN,
  input logic       busClk,
  input logic       busRstN,
  input logic [1:0] ratioSel,
  input logic       chanClk,
  input logic       ctrlDivClk,
  input logic       ctrlMark,
  input logic       chanDivClk,
  input logic       chanMark
);
  // R7: ratio code held still while a domain runs
  p_ratio_held_r7: assert property (@(posedge ctrlClk) disable iff (!ctrlRstN)
    $stable(ratioSel));

  // R8: divided rising edge only with the marker
  p_ctrl_rise_mark_r8: assert property (@(posedge ctrlClk) disable iff (!ctrlRstN)
    $rose(ctrlDivClk) |-> ctrlMark);
  p_chan_rise_mark_r8: assert property (@(posedge busClk) disable iff (!busRstN)
    $rose(chanDivClk) |-> chanMark);

  // R5: marker lasts one controller cycle unless M is 1
  p_ctrl_mark_single_r5: assert property (@(posedge ctrlClk) disable iff (!ctrlRstN)
    (ctrlMark && ratioSel != 2'b11) |=> !ctrlMark);

  // R4: channel outputs move only on a channel clock rising edge
  p_chan_div_edge_r4: assert property (@(posedge busClk) disable iff (!busRstN)
    !$stable(chanDivClk) |-> $rose(chanClk));
  p_chan_mark_edge_r4: assert property (@(posedge busClk) disable iff (!busRstN)
    !$stable(chanMark) |-> $rose(chanClk));
endmodule

bind gear_div_pair gear_div_pair_chk u_chk (.*);

// File: tb/gear_div_pair_test.sv
`timescale 1ns/1ps
module gear_div_pair_test;
  logic       ctrlClk = 1'b0;
  logic       busClk  = 1'b0;
  logic       ctrlRstN = 1'b0;
  logic       busRstN  = 1'b0;
  logic [1:0] ratioSel = 2'b00;
  logic       chanClk, ctrlDivClk, ctrlMark, chanDivClk, chanMark;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam int FIRST = 3;  // release latency: two sync stages plus one update edge

  always #10  ctrlClk = ~ctrlClk;  // 50 MHz
  always #2.5 busClk  = ~busClk;

  gear_div_pair uut (
    .ctrlClk(ctrlClk), .ctrlRstN(ctrlRstN), .busClk(busClk), .busRstN(busRstN),
    .ratioSel(ratioSel), .chanClk(chanClk), .ctrlDivClk(ctrlDivClk),
    .ctrlMark(ctrlMark), .chanDivClk(chanDivClk), .chanMark(chanMark)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int mOf(input int code);
    case (code) 0: return 2; 1: return 3; 2: return 4; default: return 1; endcase
  endfunction
  function automatic int nOf(input int code);
    case (code) 0: return 1; 1: return 2; 2: return 3; default: return 1; endcase
  endfunction
  function automatic int hiOf(input int d);
    return (d == 1) ? 1 : d / 2;
  endfunction

  task automatic runCtrl(input int m);
    for (int n = 1; n <= FIRST + 3 * m + 2; n++) begin
      int slot;
      @(posedge ctrlClk); @(negedge ctrlClk);
      slot = (n - FIRST) % m;
      if (n < FIRST) begin
        check("R6", "ctrlMark before first update", int'(ctrlMark), 0);
      end else begin
        check("R2", "ctrlDivClk", int'(ctrlDivClk), int'(slot < hiOf(m)));
        check("R5", "ctrlMark", int'(ctrlMark), int'(slot == 0));
      end
    end
  endtask

  task automatic runChan(input int nd);
    for (int n = 1; n <= FIRST + 4 * 3 * nd + 4; n++) begin
      int c;
      @(posedge busClk); @(negedge busClk);
      if (n < FIRST) begin
        check("R6", "chanClk before first update", int'(chanClk), 0);
      end else begin
        c = ((n - FIRST) / 4) % nd;
        check("R3", "chanClk", int'(chanClk), int'(((n - FIRST) % 4) < 2));
        check("R4", "chanDivClk", int'(chanDivClk), int'(c < hiOf(nd)));
        check("R5", "chanMark", int'(chanMark), int'(c == 0));
      end
    end
  endtask

  initial begin
    #150000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge ctrlClk);
    // R6: reset state
    check("R6", "ctrlDivClk in reset", int'(ctrlDivClk), 0);
    check("R6", "ctrlMark in reset", int'(ctrlMark), 0);
    check("R6", "chanClk in reset", int'(chanClk), 0);
    check("R6", "chanDivClk in reset", int'(chanDivClk), 0);
    check("R6", "chanMark in reset", int'(chanMark), 0);

    // R1, R7: sweep every ratio code; each step resets mid-period and
    // passes through a different code during reset first.
    for (int k = 0; k < 8; k++) begin
      int code;
      code = (k * 3 + 2) % 4;
      @(negedge ctrlClk);
      ctrlRstN = 1'b0;
      busRstN  = 1'b0;
      @(negedge ctrlClk);
      ratioSel = 2'(code + 1);
      @(negedge ctrlClk);
      ratioSel = 2'(code);
      repeat (2) @(negedge ctrlClk);
      check("R6", "ctrlMark after reset", int'(ctrlMark), 0);
      check("R6", "chanMark after reset", int'(chanMark), 0);
      ctrlRstN = 1'b1;
      runCtrl(mOf(code));   // R1, R7: M from the code held at release
      @(negedge busClk);
      busRstN = 1'b1;
      runChan(nOf(code));   // R1, R7: N from the code held at release
      // R8: stop in the middle of a period before the next step
      repeat (k % 3) @(negedge busClk);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule